// File: doc/BRIEF.md
# Coprocessor Job Launcher: Descriptor Fetch and Dispatch

This unit is the command front end of a CPU-attached compute coprocessor. Software prepares a job descriptor in memory, hands its base address to the unit with one command, and then kicks the job off with a second command. On the kick the unit walks the descriptor itself, one 64-bit word per read, over a simple request/response memory port. When the last word has arrived it decodes the operation code. It then strobes the start input of the matching engine: matrix multiply, attention or causal attention.

While an engine works, the unit reports busy and presents the remaining descriptor words (addresses and problem dimensions) on a shared parameter bus. It returns to idle only when the selected engine reports done. A small bank of performance counters measures the job. Software can zero the counters with a command and read any one of them by index. The value comes back on a response port.

Top module: `desc_dispatch_unit`

## Requirements
- R1: After reset the unit is idle: busy, all start strobes, the memory request, the response valid and both error flags are low, and every counter reads zero.
- R2: A command with code 0 latches cmd_data as the descriptor base address. A command with code 1 (launch) accepted while idle starts a fetch from that base.
- R3: The fetch issues DESC_WORDS read requests, one at a time, to addresses base + 8*i for i = 0, 1, 2 and so on. Each request is held steady until mem_req_ready, and the next request follows only after the previous response has arrived.
- R4: The low 4 bits of descriptor word 0 select the engine: 1 = matrix multiply, 2 = attention, 3 = causal attention. Exactly one matching start strobe pulses for one cycle. job_params carries words 1 to DESC_WORDS-1, with word 1 in the least significant 64 bits, and holds them until done.
- R5: busy stays high from launch until the selected engine's done input is seen. Done inputs of the other engines have no effect.
- R6: Counter 0 counts every cycle in which busy is high and holds its value while idle. A command with code 2 zeroes all counters.
- R7: A launch that arrives while busy is rejected. It sets err_launch_busy, which stays set until reset, and the job in progress is neither restarted nor refetched.
- R8: An operation code outside 1 to 3 strobes no engine. The unit returns to idle and sets err_bad_op, which clears on the next accepted launch.
- R9: A command with code 3 reads the counter selected by cmd_data[1:0]. rsp_valid pulses for one cycle in the cycle after acceptance, with the value zero-extended on rsp_data. Index 3 reads zero.
- R10: Counter 1 counts jobs completed by an engine's done. Counter 2 counts rejected launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_funct | input | 3 | Command code: 0 set base, 1 launch, 2 clear counters, 3 read counter |
| cmd_data | input | 64 | Base address or counter index |
| rsp_valid | output | 1 | Counter read result valid |
| rsp_data | output | 64 | Counter read result |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned descriptor word |
| mm_go | output | 1 | Start strobe, matrix multiply engine |
| attn_go | output | 1 | Start strobe, attention engine |
| causal_go | output | 1 | Start strobe, causal attention engine |
| job_params | output | (DESC_WORDS-1)*64 | Descriptor words 1 and up |
| mm_done | input | 1 | Matrix multiply engine finished |
| attn_done | input | 1 | Attention engine finished |
| causal_done | input | 1 | Causal attention engine finished |
| busy | output | 1 | A job is being fetched or run |
| err_launch_busy | output | 1 | Sticky: a launch arrived while busy |
| err_bad_op | output | 1 | Last descriptor carried an unknown operation code |

## Verification
The bench builds the block with its defaults: ADDR_W = 32, DESC_WORDS = 8 and CNT_W = 48. An eight-word walk therefore spans one full 64-byte slot of the bench memory, so a wrong stride, a skipped word or a refetch shows up both in the address stream and in the 448-bit parameter bus. The memory model can stall every other request. Engine latencies from one cycle to thirty let the bench land a rival launch and foreign done pulses inside a running job, and then compare the busy-cycle counter against the number of busy cycles it saw at the ports.

// File: rtl/ddu_pkg.sv
package ddu_pkg;

    localparam int WORD_W   = 64;
    localparam int FUNCT_W  = 3;
    localparam int NUM_ENG  = 3;

    typedef enum logic [FUNCT_W-1:0] {
        CMD_SET_BASE = 3'd0,
        CMD_LAUNCH   = 3'd1,
        CMD_CLEAR    = 3'd2,
        CMD_READ     = 3'd3
    } cmd_code_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_MM     = 2'd1,
        OP_ATTN   = 2'd2,
        OP_CAUSAL = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DISPATCH,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic             set_base;
        logic             launch;
        logic             clear;
        logic             read;
        logic [1:0]       idx;
        logic [WORD_W-1:0] data;
    } cmd_dec_t;

    function automatic op_kind_e decode_op(input logic [3:0] code);
        case (code)
            4'd1:    return OP_MM;
            4'd2:    return OP_ATTN;
            4'd3:    return OP_CAUSAL;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic int unsigned eng_index(input op_kind_e k);
        case (k)
            OP_MM:     return 0;
            OP_ATTN:   return 1;
            default:   return 2;
        endcase
    endfunction

endpackage

// File: rtl/ddu_cmd_decode.sv
module ddu_cmd_decode
    import ddu_pkg::*;
(
    input  logic                cmd_valid,
    input  logic [FUNCT_W-1:0]  cmd_funct,
    input  logic [WORD_W-1:0]   cmd_data,
    output cmd_dec_t            dec
);

    always_comb begin
        dec          = '0;
        dec.data     = cmd_data;
        dec.idx      = cmd_data[1:0];
        if (cmd_valid) begin
            case (cmd_funct)
                CMD_SET_BASE: dec.set_base = 1'b1;
                CMD_LAUNCH:   dec.launch   = 1'b1;
                CMD_CLEAR:    dec.clear    = 1'b1;
                CMD_READ:     dec.read     = 1'b1;
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/ddu_fetch_seq.sv
module ddu_fetch_seq
    import ddu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DESC_WORDS = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              launch,
    input  logic [WORD_W-1:0]                 base,
    output logic                              mem_req_valid,
    input  logic                              mem_req_ready,
    output logic [ADDR_W-1:0]                 mem_req_addr,
    input  logic                              mem_rsp_valid,
    input  logic [WORD_W-1:0]                 mem_rsp_data,
    input  logic [NUM_ENG-1:0]                eng_done,
    output logic [NUM_ENG-1:0]                eng_go,
    output logic [(DESC_WORDS-1)*WORD_W-1:0]  params,
    output logic                              busy,
    output logic                              launch_taken,
    output logic                              launch_reject,
    output logic                              job_finished,
    output logic                              bad_op
);

    localparam int IDX_W  = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;
    localparam int BYTE_SH = 3;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    seq_state_e          state;
    logic [IDX_W-1:0]    idx;
    logic [WORD_W-1:0]   base_q;
    op_kind_e            sel;
    op_kind_e            kind;
    logic [WORD_W-1:0]   words [DESC_WORDS];
    logic [WORD_W-1:0]   addr_full;
    logic                done_sel;

    assign kind = decode_op(words[0][3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            base_q <= '0;
            sel    <= OP_NONE;
            for (int w = 0; w < DESC_WORDS; w++) begin
                words[w] <= '0;
            end
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        base_q <= base;
                        idx    <= '0;
                        state  <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        words[idx] <= mem_rsp_data;
                        if (idx == LAST_IDX) begin
                            state <= ST_DISPATCH;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_REQ;
                        end
                    end
                end
                ST_DISPATCH: begin
                    sel   <= kind;
                    state <= (kind == OP_NONE) ? ST_IDLE : ST_RUN;
                end
                ST_RUN: begin
                    if (done_sel) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (sel)
            OP_MM:     done_sel = eng_done[0];
            OP_ATTN:   done_sel = eng_done[1];
            OP_CAUSAL: done_sel = eng_done[2];
            default:   done_sel = 1'b0;
        endcase
    end

    assign addr_full     = base_q + (WORD_W'(idx) << BYTE_SH);
    assign mem_req_addr  = addr_full[ADDR_W-1:0];
    assign mem_req_valid = (state == ST_REQ);
    assign busy          = (state != ST_IDLE);
    assign launch_taken  = launch && (state == ST_IDLE);
    assign launch_reject = launch && (state != ST_IDLE);
    assign job_finished  = (state == ST_RUN) && done_sel;
    assign bad_op        = (state == ST_DISPATCH) && (kind == OP_NONE);

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_go
        assign eng_go[e] = (state == ST_DISPATCH) && (kind != OP_NONE)
                           && (eng_index(kind) == e);
    end

    for (genvar g = 1; g < DESC_WORDS; g++) begin : g_params
        assign params[(g-1)*WORD_W +: WORD_W] = words[g];
    end

endmodule

// File: rtl/ddu_perf_counters.sv
module ddu_perf_counters
    import ddu_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int NUM_CNT = 3,
    parameter int IDX_W   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic [NUM_CNT-1:0]  inc,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                rsp_valid,
    output logic [WORD_W-1:0]   rsp_data,
    output logic [CNT_W-1:0]    cnt_first
);

    logic [CNT_W-1:0] cnt [NUM_CNT];
    logic [CNT_W-1:0] pick;

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                cnt[c] <= '0;
            end else if (inc[c]) begin
                cnt[c] <= cnt[c] + 1'b1;
            end
        end
    end

    always_comb begin
        pick = '0;
        for (int c = 0; c < NUM_CNT; c++) begin
            if (rd_idx == IDX_W'(c)) begin
                pick = cnt[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                rsp_data <= WORD_W'(pick);
            end
        end
    end

    assign cnt_first = cnt[0];

endmodule

// File: rtl/desc_dispatch_unit.sv
module desc_dispatch_unit
    import ddu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DESC_WORDS = 8,
    parameter int CNT_W      = 48
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cmd_valid,
    input  logic [2:0]                        cmd_funct,
    input  logic [63:0]                       cmd_data,
    output logic                              rsp_valid,
    output logic [63:0]                       rsp_data,
    output logic                              mem_req_valid,
    input  logic                              mem_req_ready,
    output logic [ADDR_W-1:0]                 mem_req_addr,
    input  logic                              mem_rsp_valid,
    input  logic [63:0]                       mem_rsp_data,
    output logic                              mm_go,
    output logic                              attn_go,
    output logic                              causal_go,
    output logic [(DESC_WORDS-1)*64-1:0]      job_params,
    input  logic                              mm_done,
    input  logic                              attn_done,
    input  logic                              causal_done,
    output logic                              busy,
    output logic                              err_launch_busy,
    output logic                              err_bad_op
);

    localparam int NUM_CNT = 3;
    localparam int CIDX_W  = 2;

    cmd_dec_t             dec;
    logic [NUM_ENG-1:0]   go_vec;
    logic                 launch_taken;
    logic                 launch_reject;
    logic                 job_finished;
    logic                 bad_op;
    logic [WORD_W-1:0]    base_reg;
    logic [CNT_W-1:0]     total_cnt;

    ddu_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_funct (cmd_funct),
        .cmd_data  (cmd_data),
        .dec       (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_reg <= '0;
        end else if (dec.set_base) begin
            base_reg <= dec.data;
        end
    end

    ddu_fetch_seq #(
        .ADDR_W     (ADDR_W),
        .DESC_WORDS (DESC_WORDS)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .launch        (dec.launch),
        .base          (base_reg),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .eng_done      ({causal_done, attn_done, mm_done}),
        .eng_go        (go_vec),
        .params        (job_params),
        .busy          (busy),
        .launch_taken  (launch_taken),
        .launch_reject (launch_reject),
        .job_finished  (job_finished),
        .bad_op        (bad_op)
    );

    assign mm_go     = go_vec[0];
    assign attn_go   = go_vec[1];
    assign causal_go = go_vec[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            err_launch_busy <= 1'b0;
            err_bad_op      <= 1'b0;
        end else begin
            if (launch_reject) begin
                err_launch_busy <= 1'b1;
            end
            if (bad_op) begin
                err_bad_op <= 1'b1;
            end else if (launch_taken) begin
                err_bad_op <= 1'b0;
            end
        end
    end

    ddu_perf_counters #(
        .CNT_W   (CNT_W),
        .NUM_CNT (NUM_CNT),
        .IDX_W   (CIDX_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clear     (dec.clear),
        .inc       ({launch_reject, job_finished, busy}),
        .rd_en     (dec.read),
        .rd_idx    (dec.idx),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .cnt_first (total_cnt)
    );

endmodule

// File: rtl/desc_dispatch_unit_chk.sv
module desc_dispatch_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_funct,
    input logic              rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mm_go,
    input logic              attn_go,
    input logic              causal_go,
    input logic              busy,
    input logic              err_launch_busy,
    input logic [CNT_W-1:0]  total_cnt
);

    // R3
    fetch_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4
    go_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mm_go, attn_go, causal_go}));

    // R4
    go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (mm_go || attn_go || causal_go) |=> (busy && !(mm_go || attn_go || causal_go)));

    // R6
    total_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(cmd_valid && cmd_funct == 3'd2)) |=> $stable(total_cnt));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_launch_busy |=> err_launch_busy);

    // R9
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid && cmd_funct == 3'd3));

endmodule

bind desc_dispatch_unit desc_dispatch_unit_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_valid       (cmd_valid),
    .cmd_funct       (cmd_funct),
    .rsp_valid       (rsp_valid),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mm_go           (mm_go),
    .attn_go         (attn_go),
    .causal_go       (causal_go),
    .busy            (busy),
    .err_launch_busy (err_launch_busy),
    .total_cnt       (total_cnt)
);

// File: tb/desc_dispatch_unit_bench.sv
module desc_dispatch_unit_bench;

    localparam int AW = 32;
    localparam int DW = 8;
    localparam int CW = 48;
    localparam int PW = (DW - 1) * 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_funct = '0;
    logic [63:0]   cmd_data = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_data;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid;
    logic [63:0]   mem_rsp_data;
    logic          mm_go, attn_go, causal_go;
    logic [PW-1:0] job_params;
    logic          mm_done, attn_done, causal_done;
    logic          busy, err_launch_busy, err_bad_op;

    always #4 clk = ~clk;

    desc_dispatch_unit #(.ADDR_W(AW), .DESC_WORDS(DW), .CNT_W(CW)) u_desc_dispatch_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_funct(cmd_funct), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mm_go(mm_go), .attn_go(attn_go), .causal_go(causal_go), .job_params(job_params),
        .mm_done(mm_done), .attn_done(attn_done), .causal_done(causal_done),
        .busy(busy), .err_launch_busy(err_launch_busy), .err_bad_op(err_bad_op)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model
    logic [63:0] mem [64];
    logic [1:0]  stall_ctr = '0;
    bit          slow_mem = 0;
    int          req_count = 0;
    int          addr_err = 0;
    logic [63:0] op_base = '0;
    int          req_in_op = 0;

    assign mem_req_ready = slow_mem ? stall_ctr[0] : 1'b1;

    always @(posedge clk) begin
        stall_ctr <= stall_ctr + 1'b1;
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            mem_rsp_data  <= mem[mem_req_addr[8:3]];
            if (mem_req_valid && mem_req_ready) begin
                if (64'(mem_req_addr) != op_base + 64'(8 * req_in_op)) addr_err++;
                req_in_op++;
                req_count++;
            end
        end
    end

    // engine models
    int lat_mm = 5, lat_attn = 3, lat_causal = 1;
    int rem_mm = 0, rem_attn = 0, rem_causal = 0;
    logic inj_mm = 0, inj_attn = 0, inj_causal = 0;

    assign mm_done     = (rem_mm == 1) | inj_mm;
    assign attn_done   = (rem_attn == 1) | inj_attn;
    assign causal_done = (rem_causal == 1) | inj_causal;

    always @(posedge clk) begin
        if (rst) begin
            rem_mm <= 0; rem_attn <= 0; rem_causal <= 0;
        end else begin
            if (mm_go) rem_mm <= lat_mm; else if (rem_mm != 0) rem_mm <= rem_mm - 1;
            if (attn_go) rem_attn <= lat_attn; else if (rem_attn != 0) rem_attn <= rem_attn - 1;
            if (causal_go) rem_causal <= lat_causal; else if (rem_causal != 0) rem_causal <= rem_causal - 1;
        end
    end

    // port monitors
    int          busy_seen = 0;
    int          n_mm = 0, n_attn = 0, n_causal = 0;
    int          param_err = 0;
    logic [PW-1:0] exp_params = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_seen++;
            if (mm_go) n_mm++;
            if (attn_go) n_attn++;
            if (causal_go) n_causal++;
            if ((mm_go || attn_go || causal_go) && job_params != exp_params) param_err++;
        end
    end

    // scoreboard for counter reads
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected response", rsp_data, 64'd0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_data == e, t, rsp_data, e);
            end
        end
    end

    task automatic send_cmd(input logic [2:0] f, input logic [63:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_funct = f; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_funct = '0; cmd_data = '0;
    endtask

    task automatic read_cnt(input int idx, input logic [63:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_funct = 3'd3; cmd_data = 64'(idx);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_funct = '0; cmd_data = '0;
        chk(rsp_valid == 1'b1, "R9 response one cycle after read", 64'(rsp_valid), 64'd1);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic prep(input logic [63:0] base);
        for (int g = 1; g < DW; g++) exp_params[(g-1)*64 +: 64] = mem[base[8:3] + 6'(g)];
        op_base   = base;
        req_in_op = 0;
        send_cmd(3'd0, base);
    endtask

    task automatic fill_desc(input int slot, input logic [3:0] op);
        mem[slot*8] = 64'hABCD_0000_0000_0010 | 64'(op);
        for (int g = 1; g < DW; g++) mem[slot*8+g] = 64'h1111_0000_0000_0000 * 64'(slot + 1) + 64'(g * 3);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int rq, done_ops;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        fill_desc(0, 4'd1);
        fill_desc(1, 4'd2);
        fill_desc(2, 4'd3);
        fill_desc(3, 4'd7);
        done_ops = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy after reset", 64'(busy), 0);
        chk(!mem_req_valid && !rsp_valid, "R1 req/rsp idle", 64'({mem_req_valid, rsp_valid}), 0);
        chk(!(mm_go || attn_go || causal_go), "R1 no strobes", 64'({mm_go, attn_go, causal_go}), 0);
        chk(!err_launch_busy && !err_bad_op, "R1 errors clear", 64'({err_launch_busy, err_bad_op}), 0);
        read_cnt(0, 64'd0, "R1 counter zero after reset");

        // R2 R3 R4 matrix multiply, fast memory
        prep(64'h0);
        rq = req_count;
        send_cmd(3'd1, 64'd0);
        chk(busy, "R2 busy after launch", 64'(busy), 1);
        wait_idle();
        done_ops++;
        chk(req_count - rq == DW, "R3 word count mm", 64'(req_count - rq), 64'(DW));
        chk(addr_err == 0, "R3 address sequence", 64'(addr_err), 0);
        chk(n_mm == 1 && n_attn == 0 && n_causal == 0, "R4 mm strobe", 64'({n_mm, n_attn, n_causal}), 64'd1);
        chk(param_err == 0, "R4 parameter bus", 64'(param_err), 0);
        read_cnt(0, 64'(busy_seen), "R6 busy cycles");
        repeat (6) @(negedge clk);
        read_cnt(0, 64'(busy_seen), "R6 holds while idle");
        read_cnt(1, 64'(done_ops), "R10 completed jobs");

        // R5 R7 attention, stalling memory, rival done and launch
        slow_mem = 1; lat_attn = 30;
        prep(64'h40);
        rq = req_count;
        send_cmd(3'd1, 64'd0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (attn_go) break;
        end
        @(negedge clk);
        inj_mm = 1; inj_causal = 1;
        @(negedge clk); @(negedge clk);
        inj_mm = 0; inj_causal = 0;
        chk(busy, "R5 foreign done ignored", 64'(busy), 1);
        send_cmd(3'd1, 64'd0);
        chk(err_launch_busy, "R7 rejected launch flagged", 64'(err_launch_busy), 1);
        chk(busy, "R7 job continues", 64'(busy), 1);
        wait_idle();
        done_ops++;
        chk(req_count - rq == DW, "R7 no refetch", 64'(req_count - rq), 64'(DW));
        chk(n_attn == 1 && n_mm == 1, "R4 attention strobe", 64'({n_mm, n_attn}), 64'h1_0000_0001);
        chk(addr_err == 0 && param_err == 0, "R3 stalled fetch", 64'(addr_err + param_err), 0);

        // R4 causal attention, single-cycle engine
        slow_mem = 0;
        prep(64'h80);
        send_cmd(3'd1, 64'd0);
        wait_idle();
        done_ops++;
        chk(n_causal == 1, "R4 causal strobe", 64'(n_causal), 1);
        chk(err_launch_busy, "R7 flag sticky", 64'(err_launch_busy), 1);

        // R8 unknown opcode
        prep(64'hC0);
        rq = n_mm + n_attn + n_causal;
        send_cmd(3'd1, 64'd0);
        wait_idle();
        chk(err_bad_op, "R8 bad opcode flagged", 64'(err_bad_op), 1);
        chk(n_mm + n_attn + n_causal == rq, "R8 no strobe", 64'(n_mm + n_attn + n_causal), 64'(rq));
        prep(64'h0);
        send_cmd(3'd1, 64'd0);
        chk(!err_bad_op, "R8 cleared by launch", 64'(err_bad_op), 0);
        wait_idle();
        done_ops++;

        // R6 R9 R10 counter bank
        read_cnt(1, 64'(done_ops), "R10 completed jobs total");
        read_cnt(2, 64'd1, "R10 rejected launches");
        read_cnt(3, 64'd0, "R9 index 3 reads zero");
        read_cnt(0, 64'(busy_seen), "R6 busy cycles total");
        send_cmd(3'd2, 64'd0);
        busy_seen = 0;
        read_cnt(0, 64'd0, "R6 cleared total");
        read_cnt(1, 64'd0, "R6 cleared completed");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all responses seen", 64'(exp_q.size()), 0);
        finish_run();
    end

endmodule